// File: doc/BRIEF.md
# Two-Way Time Exchange Slave with Offset Correction

This block sits on the slave end of a two-way time transfer between a master clock and a local clock. It runs a local nanosecond counter that starts at zero and advances by a fixed step on every clock cycle. Four timestamps are gathered:

- two are local samples, taken when a sync message is seen on the line and when a delay request goes out;
- two are master times, handed in later with a follow-up message and a delay response.

Once all four are present, the block works out how far the local clock sits from the master and the one-way line delay. In the same cycle it steps the local counter by the negated offset, so no increment is lost. The exchange is meant to repeat at intervals, so the correction tracks any change in path length.

Each completed exchange raises a one-cycle valid flag next to the new offset and delay values. The delay value is what the slave reports back toward the master. If a follow-up or a delay response fails to appear within a bounded number of cycles, the half-built exchange is dropped and the clock is left alone. Message parsing, the network stack and rate servoing belong to other blocks.

Top module: `tsync_slave`

## Requirements
- R1: While reset is applied, the local time, offset, delay and valid outputs are all zero.
- R2: On every cycle that completes no exchange, the local time grows by exactly STEP_NS (modulo 2^TW).
- R3: The local samples for sync arrival (t2) and request departure (t3) equal the local time output during the cycle in which the corresponding strobe is high, before that edge's update.
- R4: Exchanges follow the order sync, follow-up, request, response. A follow-up, request or response strobe in the idle state is ignored. A sync strobe while an exchange is waiting discards it and starts over with a fresh t2.
- R5: The offset is ((t2-t1)-(t4-t3)) arithmetically shifted right by one, and the delay is ((t2-t1)+(t4-t3)) arithmetically shifted right by one. Both use signed two's-complement TW-bit arithmetic, so odd values round toward minus infinity.
- R6: On the edge that accepts the delay response, the local time becomes its previous value plus STEP_NS minus the new offset.
- R7: The valid output is high for exactly the one cycle after the accepting edge. The offset and delay outputs hold their values until the next completed exchange.
- R8: A follow-up must be sampled within TIMEOUT_CYC edges after the edge that took the sync, and a response within TIMEOUT_CYC edges after the edge that took the request. Otherwise the exchange is dropped, and no result or correction follows from the late strobes.
- R9: A sync strobe in the same cycle as an accepted response both completes the current exchange and opens a new one, whose t2 is the pre-correction local time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sync_rx_i | input | 1 | Strobe: sync message arrived, latch t2 |
| req_tx_i | input | 1 | Strobe: delay request transmitted, latch t3 |
| fup_vld_i | input | 1 | Strobe: master sync departure time present |
| fup_time_i | input | TW | Master time t1 (ns) |
| resp_vld_i | input | 1 | Strobe: master request arrival time present |
| resp_time_i | input | TW | Master time t4 (ns) |
| local_time_o | output | TW | Local time (ns) |
| offset_o | output | TW | Last offset, local minus master, two's complement |
| delay_o | output | TW | Last one-way path delay, two's complement |
| result_vld_o | output | 1 | One-cycle pulse for a new offset/delay pair |

## Verification
Two things can land on one edge: the clock step that closes an exchange, and the capture of a new t2 from a sync strobe. The bench provokes this by raising the sync strobe in the very cycle it presents the delay response. It first judges the correction on the step itself. It then completes the following exchange without a further sync, and checks that the resulting offset matches one computed from the uncorrected time seen in that shared cycle.

// File: rtl/tsync_pkg.sv
package tsync_pkg;

  // Progress of one two-way exchange.
  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_WAIT_T1  = 2'd1,
    ST_WAIT_REQ = 2'd2,
    ST_WAIT_T4  = 2'd3
  } xchg_state_e;

endpackage

// File: rtl/tsync_timebase.sv
module tsync_timebase #(
  parameter int TW      = 64,
  parameter int STEP_NS = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          corr_en_i,
  input  logic [TW-1:0] corr_i,
  output logic [TW-1:0] time_o
);

  localparam logic [TW-1:0] STEP = TW'(STEP_NS);

  logic [TW-1:0] time_q;
  logic [TW-1:0] time_d;
  logic [TW-1:0] adj;

  // The step and the correction are folded into one add, so the
  // cycle that applies a correction still advances by STEP.
  always_comb begin
    adj    = corr_en_i ? (STEP - corr_i) : STEP;
    time_d = time_q + adj;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      time_q <= '0;
    end else begin
      time_q <= time_d;
    end
  end

  assign time_o = time_q;

endmodule

// File: rtl/tsync_sequencer.sv
module tsync_sequencer
  import tsync_pkg::*;
#(
  parameter int TW          = 64,
  parameter int TIMEOUT_CYC = 1000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sync_i,
  input  logic          req_i,
  input  logic          t1_vld_i,
  input  logic [TW-1:0] t1_i,
  input  logic          t4_vld_i,
  input  logic [TW-1:0] t4_i,
  input  logic [TW-1:0] now_i,
  output logic          done_o,
  output logic [TW-1:0] t1_o,
  output logic [TW-1:0] t2_o,
  output logic [TW-1:0] t3_o,
  output logic [TW-1:0] t4_o
);

  localparam int TMR_W = $clog2(TIMEOUT_CYC + 1);
  localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(TIMEOUT_CYC - 1);

  xchg_state_e    state_q, state_d;
  logic [TMR_W-1:0] tmr_q, tmr_d;
  logic [TW-1:0]  t1_q, t2_q, t3_q;
  logic           cap_t1, cap_t2, cap_t3;
  logic           evt;
  logic           expire;
  logic           timing;

  assign expire = (tmr_q == TMR_LAST);

  // Next-state decode. A response beats a sync in the same cycle:
  // it completes the exchange, and the sync then opens the next one.
  always_comb begin
    state_d = state_q;
    cap_t1  = 1'b0;
    cap_t2  = 1'b0;
    cap_t3  = 1'b0;
    done_o  = 1'b0;
    evt     = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (sync_i) begin
          cap_t2  = 1'b1;
          evt     = 1'b1;
          state_d = ST_WAIT_T1;
        end
      end
      ST_WAIT_T1: begin
        if (sync_i) begin
          cap_t2 = 1'b1;
          evt    = 1'b1;
        end else if (t1_vld_i) begin
          cap_t1  = 1'b1;
          evt     = 1'b1;
          state_d = ST_WAIT_REQ;
        end else if (expire) begin
          state_d = ST_IDLE;
        end
      end
      ST_WAIT_REQ: begin
        if (sync_i) begin
          cap_t2  = 1'b1;
          evt     = 1'b1;
          state_d = ST_WAIT_T1;
        end else if (req_i) begin
          cap_t3  = 1'b1;
          evt     = 1'b1;
          state_d = ST_WAIT_T4;
        end
      end
      ST_WAIT_T4: begin
        if (t4_vld_i) begin
          done_o = 1'b1;
          evt    = 1'b1;
          if (sync_i) begin
            cap_t2  = 1'b1;
            state_d = ST_WAIT_T1;
          end else begin
            state_d = ST_IDLE;
          end
        end else if (sync_i) begin
          cap_t2  = 1'b1;
          evt     = 1'b1;
          state_d = ST_WAIT_T1;
        end else if (expire) begin
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // The wait timer runs only while a master time is awaited and
  // restarts on every accepted strobe.
  assign timing = (state_q == ST_WAIT_T1) || (state_q == ST_WAIT_T4);

  always_comb begin
    if (evt || !timing) begin
      tmr_d = '0;
    end else begin
      tmr_d = tmr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      tmr_q   <= '0;
    end else begin
      state_q <= state_d;
      tmr_q   <= tmr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t1_q <= '0;
      t2_q <= '0;
      t3_q <= '0;
    end else begin
      if (cap_t1) t1_q <= t1_i;
      if (cap_t2) t2_q <= now_i;
      if (cap_t3) t3_q <= now_i;
    end
  end

  assign t1_o = t1_q;
  assign t2_o = t2_q;
  assign t3_o = t3_q;
  assign t4_o = t4_i;

endmodule

// File: rtl/tsync_solver.sv
module tsync_solver #(
  parameter int TW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          done_i,
  input  logic [TW-1:0] t1_i,
  input  logic [TW-1:0] t2_i,
  input  logic [TW-1:0] t3_i,
  input  logic [TW-1:0] t4_i,
  output logic [TW-1:0] corr_o,
  output logic [TW-1:0] offset_o,
  output logic [TW-1:0] delay_o,
  output logic          valid_o
);

  logic signed [TW-1:0] fwd, rev, diff, sum, off_c, dly_c;
  logic [TW-1:0] offset_q, delay_q;
  logic          valid_q;

  // fwd: master-to-slave leg, rev: slave-to-master leg.
  always_comb begin
    fwd   = $signed(t2_i - t1_i);
    rev   = $signed(t4_i - t3_i);
    diff  = fwd - rev;
    sum   = fwd + rev;
    off_c = diff >>> 1;
    dly_c = sum >>> 1;
  end

  assign corr_o = off_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      offset_q <= '0;
      delay_q  <= '0;
      valid_q  <= 1'b0;
    end else begin
      valid_q <= done_i;
      if (done_i) begin
        offset_q <= off_c;
        delay_q  <= dly_c;
      end
    end
  end

  assign offset_o = offset_q;
  assign delay_o  = delay_q;
  assign valid_o  = valid_q;

endmodule

// File: rtl/tsync_slave.sv
module tsync_slave #(
  parameter int TW          = 64,
  parameter int STEP_NS     = 4,
  parameter int TIMEOUT_CYC = 1000000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sync_rx_i,
  input  logic          req_tx_i,
  input  logic          fup_vld_i,
  input  logic [TW-1:0] fup_time_i,
  input  logic          resp_vld_i,
  input  logic [TW-1:0] resp_time_i,
  output logic [TW-1:0] local_time_o,
  output logic [TW-1:0] offset_o,
  output logic [TW-1:0] delay_o,
  output logic          result_vld_o
);

  logic [1:0]    rst_pipe_q;
  logic          rst_q;
  logic          done;
  logic [TW-1:0] t1, t2, t3, t4;
  logic [TW-1:0] corr;

  // Reset asserts at once and releases after two clean edges.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end

  assign rst_q = rst_pipe_q[1];

  tsync_timebase #(
    .TW      (TW),
    .STEP_NS (STEP_NS)
  ) timebase_i (
    .clk       (clk),
    .rst_n     (rst_q),
    .corr_en_i (done),
    .corr_i    (corr),
    .time_o    (local_time_o)
  );

  tsync_sequencer #(
    .TW          (TW),
    .TIMEOUT_CYC (TIMEOUT_CYC)
  ) seq_i (
    .clk      (clk),
    .rst_n    (rst_q),
    .sync_i   (sync_rx_i),
    .req_i    (req_tx_i),
    .t1_vld_i (fup_vld_i),
    .t1_i     (fup_time_i),
    .t4_vld_i (resp_vld_i),
    .t4_i     (resp_time_i),
    .now_i    (local_time_o),
    .done_o   (done),
    .t1_o     (t1),
    .t2_o     (t2),
    .t3_o     (t3),
    .t4_o     (t4)
  );

  tsync_solver #(
    .TW (TW)
  ) solver_i (
    .clk      (clk),
    .rst_n    (rst_q),
    .done_i   (done),
    .t1_i     (t1),
    .t2_i     (t2),
    .t3_i     (t3),
    .t4_i     (t4),
    .corr_o   (corr),
    .offset_o (offset_o),
    .delay_o  (delay_o),
    .valid_o  (result_vld_o)
  );

endmodule

// File: rtl/tsync_slave_chk.sv
module tsync_slave_chk #(
  parameter int TW      = 64,
  parameter int STEP_NS = 4
) (
  input logic          clk,
  input logic          rst_q,
  input logic          resp_vld_i,
  input logic [TW-1:0] local_time_o,
  input logic [TW-1:0] offset_o,
  input logic [TW-1:0] delay_o,
  input logic          result_vld_o
);

  localparam logic [TW-1:0] STEP = TW'(STEP_NS);

  // R1: first edge out of reset still shows a zero clock
  a_r1_zero_after_reset: assert property (@(posedge clk) disable iff (!rst_q)
    !$past(rst_q) |-> (local_time_o == '0 && !result_vld_o));

  // R2: plain advance when no exchange closes
  a_r2_plain_step: assert property (@(posedge clk) disable iff (!rst_q)
    ($past(rst_q) && !result_vld_o) |-> local_time_o == $past(local_time_o) + STEP);

  // R6: correction applied together with the step
  a_r6_corrected_step: assert property (@(posedge clk) disable iff (!rst_q)
    ($past(rst_q) && result_vld_o) |-> local_time_o == $past(local_time_o) + STEP - offset_o);

  // R7: single-cycle valid pulse
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_q)
    result_vld_o |=> !result_vld_o);

  // R7: results hold between completions
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_q)
    !result_vld_o |-> ($stable(offset_o) && $stable(delay_o)));

  // R4: a result only follows an accepted response
  a_r4_needs_response: assert property (@(posedge clk) disable iff (!rst_q)
    result_vld_o |-> $past(resp_vld_i));

endmodule

bind tsync_slave tsync_slave_chk #(
  .TW      (TW),
  .STEP_NS (STEP_NS)
) chk_i (
  .clk          (clk),
  .rst_q        (rst_q),
  .resp_vld_i   (resp_vld_i),
  .local_time_o (local_time_o),
  .offset_o     (offset_o),
  .delay_o      (delay_o),
  .result_vld_o (result_vld_o)
);

// File: tb/tsync_slave_tb_top.sv
`timescale 1ns/1ps
module tsync_slave_tb_top;

  localparam int TW   = 64;
  localparam int STEP = 4;
  localparam int TMO  = 16;

  logic          clk;
  logic          rst_n;
  logic          sync_rx_i, req_tx_i, fup_vld_i, resp_vld_i;
  logic [TW-1:0] fup_time_i, resp_time_i;
  logic [TW-1:0] local_time_o, offset_o, delay_o;
  logic          result_vld_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [TW-1:0] pend_t2;

  tsync_slave #(.TW(TW), .STEP_NS(STEP), .TIMEOUT_CYC(TMO)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .sync_rx_i(sync_rx_i), .req_tx_i(req_tx_i),
    .fup_vld_i(fup_vld_i), .fup_time_i(fup_time_i),
    .resp_vld_i(resp_vld_i), .resp_time_i(resp_time_i),
    .local_time_o(local_time_o), .offset_o(offset_o),
    .delay_o(delay_o), .result_vld_o(result_vld_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One exchange. g1: edges from sync edge to follow-up edge.
  // g4: edges from request edge to response edge.
  task automatic run_xchg(input longint off, input longint dly, input longint asym,
                          input int g1, input int g4, input bit have_t2, input bit collide);
    logic [TW-1:0] t1x, t2x, t3x, t4x, tp;
    logic signed [TW-1:0] fwd, rev, dif, sm, eo, ed;
    if (have_t2) begin
      t2x = pend_t2;
    end else begin
      @(negedge clk);
      t2x = local_time_o;
      sync_rx_i = 1'b1;
      @(negedge clk);
      sync_rx_i = 1'b0;
    end
    repeat (g1 - 1) @(negedge clk);
    t1x = t2x - TW'(dly) - TW'(off);
    fup_vld_i = 1'b1; fup_time_i = t1x;
    @(negedge clk);
    fup_vld_i = 1'b0;
    t3x = local_time_o;
    req_tx_i = 1'b1;
    @(negedge clk);
    req_tx_i = 1'b0;
    repeat (g4 - 1) @(negedge clk);
    t4x = t3x + TW'(dly) - TW'(off) + TW'(asym);
    resp_vld_i = 1'b1; resp_time_i = t4x;
    tp = local_time_o;
    if (collide) begin
      sync_rx_i = 1'b1;
      pend_t2 = tp;
    end
    @(negedge clk);
    fwd = $signed(t2x - t1x);
    rev = $signed(t4x - t3x);
    dif = fwd - rev;
    sm  = fwd + rev;
    eo  = dif >>> 1;
    ed  = sm >>> 1;
    if (g1 <= TMO && g4 <= TMO) begin
      chk(result_vld_o == 1'b1, "R7 valid pulse", longint'(result_vld_o), 1);
      chk(offset_o == eo, "R3 R5 offset", longint'(offset_o), longint'(eo));
      chk(delay_o == ed, "R5 delay", longint'(delay_o), longint'(ed));
      chk(local_time_o == tp + STEP - eo, collide ? "R9 correction on shared edge" : "R6 corrected time",
          longint'(local_time_o), longint'(tp + STEP - eo));
    end else begin
      chk(result_vld_o == 1'b0, "R8 no result after timeout", longint'(result_vld_o), 0);
      chk(local_time_o == tp + STEP, "R8 no correction after timeout",
          longint'(local_time_o), longint'(tp + STEP));
    end
    resp_vld_i = 1'b0;
    sync_rx_i  = 1'b0;
    if (!collide) begin
      @(negedge clk);
      chk(result_vld_o == 1'b0, "R7 pulse ends", longint'(result_vld_o), 0);
    end
  endtask

  function automatic longint dly_of(input int i);
    case (i)
      0: return 0;
      1: return 5;
      2: return 250;
      default: return 77777;
    endcase
  endfunction

  initial begin
    logic [TW-1:0] prev;
    rst_n = 1'b0;
    sync_rx_i = 0; req_tx_i = 0; fup_vld_i = 0; resp_vld_i = 0;
    fup_time_i = '0; resp_time_i = '0;
    pend_t2 = '0;
    repeat (3) @(negedge clk);
    chk(local_time_o == '0, "R1 time in reset", longint'(local_time_o), 0);
    chk(offset_o == '0 && delay_o == '0, "R1 results in reset", longint'(offset_o), 0);
    chk(result_vld_o == 1'b0, "R1 valid in reset", longint'(result_vld_o), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      prev = local_time_o;
      @(negedge clk);
      chk(local_time_o == prev + STEP, "R2 free step", longint'(local_time_o), longint'(prev + STEP));
    end

    // R4: strobes in idle are ignored
    prev = local_time_o;
    fup_vld_i = 1; fup_time_i = 64'd123456; resp_vld_i = 1; resp_time_i = 64'd999; req_tx_i = 1;
    @(negedge clk);
    fup_vld_i = 0; resp_vld_i = 0; req_tx_i = 0;
    chk(result_vld_o == 1'b0, "R4 idle strobes ignored", longint'(result_vld_o), 0);
    chk(local_time_o == prev + STEP, "R4 idle strobes leave time", longint'(local_time_o), longint'(prev + STEP));
    @(negedge clk);
    chk(result_vld_o == 1'b0, "R4 idle strobes ignored later", longint'(result_vld_o), 0);

    // R5 R6: sweep of offsets, delays, odd asymmetry and gaps
    for (int oi = -3; oi <= 3; oi++) begin
      for (int di = 0; di < 4; di++) begin
        for (int a = 0; a < 2; a++) begin
          run_xchg(longint'(oi) * 1237 + a, dly_of(di), longint'(a) * 3,
                   1 + (((oi + 3) * 2 + di) % TMO), 1 + ((a * 5 + di * 3) % TMO), 0, 0);
        end
      end
    end

    // R8 boundaries
    run_xchg(40, 100, 0, TMO, 1, 0, 0);
    run_xchg(40, 100, 0, TMO + 1, 1, 0, 0);
    run_xchg(-75, 9, 1, 2, TMO, 0, 0);
    run_xchg(-75, 9, 1, 2, TMO + 1, 0, 0);

    // R4: restart while waiting for follow-up
    @(negedge clk); sync_rx_i = 1; @(negedge clk); sync_rx_i = 0;
    repeat (3) @(negedge clk);
    run_xchg(-500, 60, 0, 3, 2, 0, 0);
    // R4: restart while waiting for request
    @(negedge clk); sync_rx_i = 1; @(negedge clk); sync_rx_i = 0;
    fup_vld_i = 1; fup_time_i = 64'd5; @(negedge clk); fup_vld_i = 0;
    repeat (2) @(negedge clk);
    run_xchg(321, 44, 1, 2, 3, 0, 0);

    // R9: sync on the response cycle, next exchange reuses that t2
    run_xchg(800, 30, 0, 2, 2, 0, 1);
    run_xchg(-260, 12, 1, 3, 2, 1, 0);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule